// File: doc/BRIEF.md
# Slotted Interrupt Level Driver

This block lets two interrupt sources inside a peripheral share an 8-line interrupt request bus that is time-multiplexed over four slots. The bus arbiter supplies a 2-bit slot number each cycle. Each source has a 5-bit programmable level, which gives 32 levels in total. The upper two bits of the level name the slot that carries it. The lower three bits name the line within that slot. When a source has its status flag set and its enable on, it drives its one line, and only while its slot is current.

No hardware priority exists between the sources. When both sources request the same level, that line is asserted once, and software must work out which source raised it. When the two sources request different lines in the same slot, both lines are asserted.

A small write-only register port loads the two level fields and the enable bits. The bus output is registered, so each slot presents a stable value for a full cycle.

Top module: `irq_slot_drv`

## Requirements
- R1: After reset both level fields and both enables are zero, and `irq_o` is zero in every slot even when both status flags are set.
- R2: A level value L belongs to slot L[4:3] and to line L[2:0]. For a single active source, `irq_o` equals `1 << L[2:0]` when the sampled slot equals L[4:3], and zero otherwise.
- R3: A source contributes nothing unless both its status flag and its enable bit are 1.
- R4: Contributions from the two sources are ORed together. Equal levels give a single line, and different lines in the same slot give both lines.
- R5: `irq_o` is a register. After each rising edge it shows the result for the `slot_i`, status and configuration sampled at that edge, and it holds that value until the next edge.
- R6: A request stays asserted on every recurrence of its slot until its status flag or its enable is cleared. From the next edge after the clear, its line is no longer driven.
- R7: A write to a level field takes effect at the write edge. From the following edge onward, the pending request appears on the new slot and line.
- R8: Register map: address 0 loads the source 0 level from `cfg_wdata_i[4:0]`. Address 1 loads the source 1 level from `cfg_wdata_i[4:0]`. Address 2 loads the enables, with bit 0 for source 0 and bit 1 for source 1. A write to address 3 changes nothing.
- R9: No more than two lines of `irq_o` are ever asserted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| stat_i | input | 2 | Status flags, one bit for each source |
| slot_i | input | 2 | Current time slot from the arbiter |
| irq_o | output | 8 | Interrupt request lines for the sampled slot |

## Verification
The assertions rely on `slot_i`, `stat_i` and the write port being free of X and stable at every rising edge. They also rely on a write arriving as a single-cycle strobe. The bench meets these conditions by changing every input on the falling edge and by dropping `cfg_we_i` after exactly one edge. It samples outputs one nanosecond after the rising edge, or just before it when it checks that a value is held. The bench keeps its own copy of the levels and enables it has written. From that copy it predicts the expected lines for each slot, independently of the design.

// File: rtl/irq_tm_pkg.sv
package irq_tm_pkg;
  parameter int unsigned NUM_SRC = 2;
  parameter int unsigned BUS_W   = 8;
  parameter int unsigned SLOT_W  = 2;
  parameter int unsigned ADDR_W  = 2;
  parameter int unsigned DATA_W  = 8;
  localparam int unsigned LINE_W = $clog2(BUS_W);
  localparam int unsigned LVL_W  = SLOT_W + LINE_W;

  typedef enum logic [1:0] {REG_LVL, REG_EN, REG_NONE} reg_kind_e;

  function automatic reg_kind_e reg_decode(input logic [ADDR_W-1:0] a);
    if (a < ADDR_W'(NUM_SRC))       return REG_LVL;
    else if (a == ADDR_W'(NUM_SRC)) return REG_EN;
    else                            return REG_NONE;
  endfunction
endpackage

// File: rtl/irq_tm_regs.sv
module irq_tm_regs
  import irq_tm_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_o,
  output logic [NUM_SRC-1:0]              en_o
);
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;
  logic [NUM_SRC-1:0]            en_q;
  reg_kind_e                     kind;

  assign kind = reg_decode(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      en_q  <= '0;
    end else if (we_i) begin
      case (kind)
        REG_LVL: begin
          for (int i = 0; i < NUM_SRC; i++)
            if (addr_i == ADDR_W'(i)) lvl_q[i] <= wdata_i[LVL_W-1:0];
        end
        REG_EN:  en_q <= wdata_i[NUM_SRC-1:0];
        default: ;
      endcase
    end
  end

  assign lvl_o = lvl_q;
  assign en_o  = en_q;

  assert_en_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(NUM_SRC)) |=> en_o == $past(wdata_i[NUM_SRC-1:0]));
  assert_unmapped_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i > ADDR_W'(NUM_SRC)) |=> ($stable(lvl_o) && $stable(en_o)));
  assert_lvl0_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == '0) |=> lvl_o[0] == $past(wdata_i[LVL_W-1:0]));
endmodule

// File: rtl/irq_tm_src.sv
module irq_tm_src
  import irq_tm_pkg::*;
(
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic              active_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [BUS_W-1:0]  line_o
);
  logic [SLOT_W-1:0] lvl_slot;
  logic [LINE_W-1:0] lvl_line;

  assign lvl_slot = lvl_i[LVL_W-1:LINE_W];
  assign lvl_line = lvl_i[LINE_W-1:0];

  always_comb begin
    line_o = '0;
    if (active_i && lvl_slot == slot_i) line_o[lvl_line] = 1'b1;
  end
endmodule

// File: rtl/irq_slot_drv.sv
module irq_slot_drv
  import irq_tm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_addr_i,
  input  logic [7:0]         cfg_wdata_i,
  input  logic [1:0]         stat_i,
  input  logic [1:0]         slot_i,
  output logic [7:0]         irq_o
);
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
  logic [NUM_SRC-1:0]            en;
  logic [NUM_SRC-1:0]            active;
  logic [NUM_SRC-1:0][BUS_W-1:0] contrib;
  logic [BUS_W-1:0]              merged;
  logic [BUS_W-1:0]              irq_q;

  irq_tm_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .lvl_o   (lvl),
    .en_o    (en)
  );

  assign active = en & stat_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_tm_src u_src (
      .lvl_i    (lvl[g]),
      .active_i (active[g]),
      .slot_i   (slot_i),
      .line_o   (contrib[g])
    );
  end

  // no priority: plain OR merge
  always_comb begin
    merged = '0;
    for (int i = 0; i < NUM_SRC; i++) merged |= contrib[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= merged;
  end

  assign irq_o = irq_q;

  assert_line_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_o) <= NUM_SRC);
  assert_needs_request_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> $past(|(en & stat_i)));
  assert_slot_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> ($past(slot_i) == $past(lvl[0][LVL_W-1:LINE_W]) ||
                       $past(slot_i) == $past(lvl[1][LVL_W-1:LINE_W])));
  assert_quiet_when_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active == '0) |=> (irq_o == '0));
endmodule

// File: tb/sim_irq_slot_drv.sv
`timescale 1ns/1ps
module sim_irq_slot_drv;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_addr_i = '0;
  logic [7:0] cfg_wdata_i = '0;
  logic [1:0] stat_i = '0;
  logic [1:0] slot_i = '0;
  logic [7:0] irq_o;

  int checks = 0;
  int fails = 0;
  logic [4:0] m_lvl0 = '0, m_lvl1 = '0;
  logic [1:0] m_en = '0;

  irq_slot_drv u0 (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [1:0] s, input logic [1:0] st);
    logic [7:0] v = '0;
    if (m_en[0] && st[0] && m_lvl0[4:3] == s) v[m_lvl0[2:0]] = 1'b1;
    if (m_en[1] && st[1] && m_lvl1[4:3] == s) v[m_lvl1[2:0]] = 1'b1;
    return v;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (a == 2'd0) m_lvl0 = d[4:0];
    else if (a == 2'd1) m_lvl1 = d[4:0];
    else if (a == 2'd2) m_en = d[1:0];
  endtask

  task automatic step(input logic [1:0] s);
    @(negedge clk_i);
    slot_i = s;
    @(posedge clk_i);
    #1;
  endtask

  task automatic sweep(input string req);
    for (int s = 0; s < 4; s++) begin
      step(2'(s));
      chk(req, irq_o, model(2'(s), stat_i));
    end
  endtask

  task automatic t_reset;
    chk("R1", irq_o, 8'h00);
    stat_i = 2'b11;
    @(negedge clk_i); rst_ni = 1'b1;
    sweep("R1");
  endtask

  task automatic t_map;
    stat_i = 2'b01;
    wr(2'd2, 8'h01);
    wr(2'd0, 8'd13);
    for (int s = 0; s < 4; s++) begin
      step(2'(s));
      chk("R2", irq_o, (s == 1) ? 8'h20 : 8'h00);
    end
    wr(2'd0, 8'd31);
    step(2'd3); chk("R2", irq_o, 8'h80);
    step(2'd2); chk("R2", irq_o, 8'h00);
    wr(2'd1, 8'd6); wr(2'd2, 8'h02); stat_i = 2'b10;
    step(2'd0); chk("R8", irq_o, 8'h40);
    sweep("R8");
  endtask

  task automatic t_gate;
    wr(2'd0, 8'd2); wr(2'd2, 8'h01);
    stat_i = 2'b00; step(2'd0); chk("R3", irq_o, 8'h00);
    stat_i = 2'b01; step(2'd0); chk("R3", irq_o, 8'h04);
    wr(2'd2, 8'h00); step(2'd0); chk("R3", irq_o, 8'h00);
  endtask

  task automatic t_merge;
    wr(2'd2, 8'h03); stat_i = 2'b11;
    wr(2'd0, 8'd10); wr(2'd1, 8'd10);
    step(2'd1); chk("R4", irq_o, 8'h04);
    sweep("R4");
    wr(2'd1, 8'd14);
    step(2'd1); chk("R4", irq_o, 8'h44);
    chk("R9", 8'($countones(irq_o)), 8'd2);
    wr(2'd0, 8'd3); wr(2'd1, 8'd27);
    step(2'd0); chk("R4", irq_o, 8'h08);
    step(2'd3); chk("R4", irq_o, 8'h08);
  endtask

  task automatic t_timing;
    wr(2'd2, 8'h01); stat_i = 2'b01; wr(2'd0, 8'd17);
    step(2'd2); chk("R5", irq_o, 8'h02);
    @(negedge clk_i); slot_i = 2'd0;
    #2; chk("R5", irq_o, 8'h02);
    @(posedge clk_i); #1; chk("R5", irq_o, 8'h00);
  endtask

  task automatic t_persist;
    wr(2'd2, 8'h01); stat_i = 2'b01; wr(2'd0, 8'd25);
    for (int r = 0; r < 3; r++) sweep("R6");
    step(2'd3); chk("R6", irq_o, 8'h02);
    @(negedge clk_i); stat_i = 2'b00;
    @(posedge clk_i); #1; chk("R6", irq_o, 8'h00);
  endtask

  task automatic t_rewrite;
    wr(2'd2, 8'h01); stat_i = 2'b01; wr(2'd0, 8'd9);
    step(2'd1); chk("R7", irq_o, 8'h02);
    @(negedge clk_i); slot_i = 2'd2;
    cfg_we_i = 1'b1; cfg_addr_i = 2'd0; cfg_wdata_i = 8'd20;
    @(posedge clk_i); #1; chk("R7", irq_o, 8'h00);
    @(negedge clk_i); cfg_we_i = 1'b0; m_lvl0 = 5'd20;
    @(posedge clk_i); #1; chk("R7", irq_o, 8'h10);
    step(2'd1); chk("R7", irq_o, 8'h00);
  endtask

  task automatic t_ignored;
    wr(2'd2, 8'h03); stat_i = 2'b11;
    wr(2'd0, 8'd5); wr(2'd1, 8'd30);
    wr(2'd3, 8'hff);
    sweep("R8");
    step(2'd0); chk("R8", irq_o, 8'h20);
    step(2'd3); chk("R8", irq_o, 8'h40);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset;
    t_map;
    t_gate;
    t_merge;
    t_timing;
    t_persist;
    t_rewrite;
    t_ignored;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule